// File: doc/BRIEF.md
# Rank-1 Update Multiply-Accumulate Mesh

This block is a square grid of NR×NR integer multiply-accumulate cells (NR = 4 by default) that computes C += A·B. C is NR×NR, A is NR×kc and B is kc×NR. The product is formed as kc rank-1 updates. On step p, column p of A goes along the horizontal buses and row p of B goes down the vertical buses. Every cell then adds the product of the two values it receives to its own accumulator.

The operands never move between cells except over these broadcasts, and no result ever leaves its cell until readout. Cell (i,j) keeps result element (i,j). Element (i,p) of A is held in cell (i, p mod NR), and element (p,j) of B is held in cell (p mod NR, j). On each step the owning cells put their values on the buses, and every cell, owners included, takes its multiplier inputs from the buses.

Operands and starting C values are written through the column-wide load port while the mesh is idle. A start pulse then runs the steps. The done flag rises once the multiply pipeline has emptied. After that, a readout request streams one row of results per cycle. A stall input freezes the whole compute pipeline in lock step.

Top module: `rank1_mesh`

## Requirements
- R1: While the mesh is not busy, a load with `ld_en`=1 writes column field j of `ld_data` (bits j*AW upward) into cell (`ld_row`, j). The target depends on `ld_sel`. With code 0, the low DW bits go to the A store at word `ld_addr`. With code 1, the low DW bits go to the B store at word `ld_addr`. With code 2, all AW bits go to the accumulator. Code 3 writes nothing. Element (i,p) of A is held at row i, column p mod NR, word p/NR. Element (p,j) of B is held at row p mod NR, column j, word p/NR.
- R2: A run with count kc adds, to each accumulator (i,j), the sum over p < kc of A(i,p)·B(p,j). The operands are signed DW-bit values and the sum wraps modulo 2^AW.
- R3: Count the cycle in which `start` is sampled as cycle 0. With no stall, `done` first reads 1 in cycle kc+5 for kc ≥ 1, and in cycle 2 for kc = 0. `busy` is 1 from cycle 1 until `done` rises.
- R4: Each cycle with `stall`=1 freezes the step counter, the bus latches, the multiplier pipeline and the accumulators. Each such cycle delays `done` by exactly one cycle and does not change the results.
- R5: `start` is ignored while busy, while stalled, and while a readout is in progress.
- R6: Loads presented while busy change nothing.
- R7: A readout request in a cycle with `done`=1 makes `out_valid` high for NR consecutive cycles, starting the next cycle. In the r-th of those cycles, `out_row`=r and column field j of `out_data` holds accumulator (r,j).
- R8: A readout request while `done`=0 is ignored and `out_valid` stays 0.
- R9: The accumulators keep their values across runs, so a second run without reloading C accumulates on top of the first run's result.
- R10: After reset, `busy`, `done` and `out_valid` are 0 and every accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 A store, 1 B store, 2 accumulator |
| ld_row | input | log2(NR) | Cell row receiving the load |
| ld_addr | input | log2(KMAX/NR) | Word address inside the A or B store |
| ld_data | input | NR*AW | One field per column bus |
| kc | input | log2(KMAX+1) | Number of rank-1 steps, at most KMAX |
| start | input | 1 | Begin a run |
| stall | input | 1 | Freeze the compute pipeline |
| rd_go | input | 1 | Request readout of the accumulators |
| busy | output | 1 | Steps being issued or the pipeline draining |
| done | output | 1 | Run finished and results settled |
| out_valid | output | 1 | Readout row valid |
| out_row | output | log2(NR) | Index of the row on `out_data` |
| out_data | output | NR*AW | Accumulator values, one field per column |

## Verification
The hardest case to reach from the ports is a control input arriving while a run is already under way. The stimulus sets this up by pulsing `start` with a different count, and by presenting an accumulator load of all ones, in the second cycle of a run. It then confirms that the latency and every result element match an undisturbed run. Stall cycles are also placed at a fixed rhythm across both the issue phase and the drain phase, so that a leak in any single pipeline register would show up as a wrong sum or a wrong `done` cycle. A further case pulses `start` during a readout, which checks that a new run cannot begin while results are still streaming out.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  localparam logic [1:0] LD_A   = 2'd0;
  localparam logic [1:0] LD_B   = 2'd1;
  localparam logic [1:0] LD_ACC = 2'd2;
endpackage

// File: rtl/mesh_seq.sv
module mesh_seq import mesh_pkg::*; #(
  parameter int NR   = 4,
  parameter int KMAX = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       stall,
  input  logic                       rd_busy,
  input  logic [$clog2(KMAX+1)-1:0]  kc,
  output logic [$clog2(KMAX/NR)-1:0] raddr,
  output logic [$clog2(NR)-1:0]      sel1,
  output logic                       acc_add,
  output logic                       busy,
  output logic                       done
);
  localparam int SW  = $clog2(NR);
  localparam int DAW = $clog2(KMAX/NR);
  localparam int PW  = DAW + SW;
  localparam int KW  = $clog2(KMAX+1);

  seq_state_t    state;
  logic [PW-1:0] p;
  logic [KW-1:0] kc_r;
  logic          v1, v2, v3;
  logic          issue;

  assign issue   = (state == ST_RUN) && !stall;
  assign raddr   = p[PW-1:SW];
  assign acc_add = v3;
  assign busy    = (state == ST_RUN) || (state == ST_DRAIN);
  assign done    = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      p     <= '0;
      kc_r  <= '0;
      sel1  <= '0;
      v1    <= 1'b0;
      v2    <= 1'b0;
      v3    <= 1'b0;
    end else if (!stall) begin
      v1   <= issue;
      sel1 <= p[SW-1:0];
      v2   <= v1;
      v3   <= v2;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start && !rd_busy) begin
            kc_r  <= kc;
            p     <= '0;
            state <= (kc == '0) ? ST_DRAIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (KW'(p) == kc_r - KW'(1)) state <= ST_DRAIN;
          else                         p     <= p + PW'(1);
        end
        default: begin
          if (!v1 && !v2 && !v3) state <= ST_DONE;
        end
      endcase
    end
  end

  // R3
  drain_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state == ST_DRAIN) && !v1 && !v2 && !v3);

  // R4
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(state) && $stable(p) && $stable({v1, v2, v3}));

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (KW'(p) < kc_r));
endmodule

// File: rtl/mesh_mac.sv
module mesh_mac #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic                 add,
  input  logic                 ld,
  input  logic [AW-1:0]        ld_val,
  output logic signed [AW-1:0] acc
);
  logic signed [2*DW-1:0] prod;

  always_ff @(posedge clk) begin
    if (rst)     prod <= '0;
    else if (en) prod <= a * b;
  end

  always_ff @(posedge clk) begin
    if (rst)             acc <= '0;
    else if (ld)         acc <= $signed(ld_val);
    else if (en && add)  acc <= acc + prod;
  end

  // R4
  acc_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> $stable(acc));

  // R2
  acc_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!add && !ld) |=> $stable(acc));
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int DEPTH = 4,
  parameter int DAW   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 we_a,
  input  logic                 we_b,
  input  logic                 we_c,
  input  logic [DAW-1:0]       waddr,
  input  logic [DAW-1:0]       raddr,
  input  logic [AW-1:0]        wval,
  input  logic signed [DW-1:0] row_in,
  input  logic signed [DW-1:0] col_in,
  input  logic                 acc_add,
  output logic signed [DW-1:0] wl_a,
  output logic signed [DW-1:0] wl_b,
  output logic signed [AW-1:0] acc
);
  logic [DW-1:0]        amem [DEPTH];
  logic [DW-1:0]        bmem [DEPTH];
  logic signed [DW-1:0] rl_a, rl_b;

  always_ff @(posedge clk) begin
    if (we_a) amem[waddr] <= wval[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (we_b) bmem[waddr] <= wval[DW-1:0];
  end

  // write latches: local store output driven onto the buses when this cell owns the step
  always_ff @(posedge clk) begin
    if (rst) begin
      wl_a <= '0;
      wl_b <= '0;
    end else if (en) begin
      wl_a <= $signed(amem[raddr]);
      wl_b <= $signed(bmem[raddr]);
    end
  end

  // read latches: every cell, owners included, samples both buses
  always_ff @(posedge clk) begin
    if (rst) begin
      rl_a <= '0;
      rl_b <= '0;
    end else if (en) begin
      rl_a <= row_in;
      rl_b <= col_in;
    end
  end

  mesh_mac #(.DW(DW), .AW(AW)) u_mac (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .a      (rl_a),
    .b      (rl_b),
    .add    (acc_add),
    .ld     (we_c),
    .ld_val (wval),
    .acc    (acc)
  );
endmodule

// File: rtl/mesh_rdout.sv
module mesh_rdout #(
  parameter int NR = 4,
  parameter int AW = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_go,
  input  logic                  done,
  input  logic [NR*NR*AW-1:0]   acc_flat,
  output logic                  rd_busy,
  output logic                  out_valid,
  output logic [$clog2(NR)-1:0] out_row,
  output logic [NR*AW-1:0]      out_data
);
  localparam int SW = $clog2(NR);

  logic          rd_act;
  logic [SW-1:0] rc, row_sel;
  logic          go_ok;
  logic [NR*AW-1:0] row_data;

  assign go_ok   = rd_go && done && !rd_act;
  assign row_sel = go_ok ? '0 : rc;
  assign rd_busy = rd_act;

  always_comb begin
    for (int j = 0; j < NR; j++)
      row_data[j*AW +: AW] = acc_flat[(int'(row_sel)*NR + j)*AW +: AW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act    <= 1'b0;
      rc        <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
      out_data  <= '0;
    end else if (go_ok || rd_act) begin
      out_valid <= 1'b1;
      out_row   <= row_sel;
      out_data  <= row_data;
      rc        <= row_sel + SW'(1);
      rd_act    <= (row_sel != SW'(NR-1));
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R7
  row_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_row != SW'(NR-1)) |=> out_valid && (out_row == SW'($past(out_row) + SW'(1))));

  // R8
  readout_done_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> done);
endmodule

// File: rtl/rank1_mesh.sv
module rank1_mesh import mesh_pkg::*; #(
  parameter int NR   = 4,
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int KMAX = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [1:0]                 ld_sel,
  input  logic [$clog2(NR)-1:0]      ld_row,
  input  logic [$clog2(KMAX/NR)-1:0] ld_addr,
  input  logic [NR*AW-1:0]           ld_data,
  input  logic [$clog2(KMAX+1)-1:0]  kc,
  input  logic                       start,
  input  logic                       stall,
  input  logic                       rd_go,
  output logic                       busy,
  output logic                       done,
  output logic                       out_valid,
  output logic [$clog2(NR)-1:0]      out_row,
  output logic [NR*AW-1:0]           out_data
);
  localparam int SW    = $clog2(NR);
  localparam int DEPTH = KMAX / NR;
  localparam int DAW   = $clog2(DEPTH);

  logic [DAW-1:0]       raddr;
  logic [SW-1:0]        sel1;
  logic                 acc_add;
  logic                 rd_busy;
  logic                 ld_ok;
  logic signed [DW-1:0] wla [NR][NR];
  logic signed [DW-1:0] wlb [NR][NR];
  logic signed [AW-1:0] accw [NR][NR];
  logic signed [DW-1:0] row_bus [NR];
  logic signed [DW-1:0] col_bus [NR];
  logic [NR*NR*AW-1:0]  acc_flat;

  assign ld_ok = ld_en && !busy;

  mesh_seq #(.NR(NR), .KMAX(KMAX)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stall   (stall),
    .rd_busy (rd_busy),
    .kc      (kc),
    .raddr   (raddr),
    .sel1    (sel1),
    .acc_add (acc_add),
    .busy    (busy),
    .done    (done)
  );

  // data-only buses: the owner of step p drives row i from column p mod NR, column j from row p mod NR
  always_comb begin
    for (int k = 0; k < NR; k++) begin
      row_bus[k] = wla[k][sel1];
      col_bus[k] = wlb[sel1][k];
    end
  end

  for (genvar i = 0; i < NR; i++) begin : g_row
    for (genvar j = 0; j < NR; j++) begin : g_col
      logic hit;
      assign hit = ld_ok && (ld_row == SW'(i));

      mesh_pe #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .DAW(DAW)) u_pe (
        .clk     (clk),
        .rst     (rst),
        .en      (!stall),
        .we_a    (hit && (ld_sel == LD_A)),
        .we_b    (hit && (ld_sel == LD_B)),
        .we_c    (hit && (ld_sel == LD_ACC)),
        .waddr   (ld_addr),
        .raddr   (raddr),
        .wval    (ld_data[j*AW +: AW]),
        .row_in  (row_bus[i]),
        .col_in  (col_bus[j]),
        .acc_add (acc_add),
        .wl_a    (wla[i][j]),
        .wl_b    (wlb[i][j]),
        .acc     (accw[i][j])
      );

      assign acc_flat[(i*NR + j)*AW +: AW] = accw[i][j];
    end
  end

  mesh_rdout #(.NR(NR), .AW(AW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .done      (done),
    .acc_flat  (acc_flat),
    .rd_busy   (rd_busy),
    .out_valid (out_valid),
    .out_row   (out_row),
    .out_data  (out_data)
  );

  // R6
  busy_load_block_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !stall && !acc_add) |=> $stable(acc_flat));
endmodule

// File: tb/sim_rank1_mesh.sv
module sim_rank1_mesh;
  localparam int NR = 4, DW = 16, AW = 40, KMAX = 16;
  localparam int SW = 2, DAW = 2, KW = 5, DEPTH = KMAX / NR;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1, ld_en = 1'b0, start = 1'b0, stall = 1'b0, rd_go = 1'b0;
  logic [1:0]         ld_sel = '0;
  logic [SW-1:0]      ld_row = '0;
  logic [DAW-1:0]     ld_addr = '0;
  logic [NR*AW-1:0]   ld_data = '0;
  logic [KW-1:0]      kc_i = '0;
  logic               busy, done, out_valid;
  logic [SW-1:0]      out_row;
  logic [NR*AW-1:0]   out_data;

  rank1_mesh #(.NR(NR), .DW(DW), .AW(AW), .KMAX(KMAX)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_row(ld_row),
    .ld_addr(ld_addr), .ld_data(ld_data), .kc(kc_i), .start(start), .stall(stall),
    .rd_go(rd_go), .busy(busy), .done(done), .out_valid(out_valid),
    .out_row(out_row), .out_data(out_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic signed [DW-1:0] ma [NR][KMAX];
  logic signed [DW-1:0] mb [KMAX][NR];
  logic signed [AW-1:0] mc [NR][NR];

  task automatic check(input string tag, input logic signed [63:0] act, input logic signed [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill_ab(input int seed, input bit extreme);
    for (int i = 0; i < NR; i++)
      for (int p = 0; p < KMAX; p++) begin
        ma[i][p] = extreme ? 16'sh8000 : DW'((((i*7 + p*13 + seed) % 97) - 48) * 300);
        mb[p][i] = extreme ? 16'sh8000 : DW'((((p*11 + i*5 + seed*3) % 89) - 44) * 250);
      end
  endtask

  // R1: A(i,p) -> row i, column p mod NR, word p/NR; B(p,j) -> row p mod NR, column j, word p/NR
  task automatic load_ab();
    for (int a = 0; a < DEPTH; a++)
      for (int r = 0; r < NR; r++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd0; ld_row = SW'(r); ld_addr = DAW'(a);
        for (int j = 0; j < NR; j++) ld_data[j*AW +: AW] = AW'(ma[r][a*NR + j]);
        @(negedge clk);
        ld_sel = 2'd1;
        for (int j = 0; j < NR; j++) ld_data[j*AW +: AW] = AW'(mb[a*NR + r][j]);
      end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_c(input int seed, input bit zero);
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_sel = 2'd2; ld_row = SW'(i);
      for (int j = 0; j < NR; j++) begin
        mc[i][j] = zero ? '0 : AW'(seed*100003 - i*77777 + j*12345 - 150000);
        ld_data[j*AW +: AW] = mc[i][j];
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic model(input int kc);
    for (int i = 0; i < NR; i++)
      for (int j = 0; j < NR; j++)
        for (int p = 0; p < kc; p++)
          mc[i][j] = mc[i][j] + ma[i][p] * mb[p][j];
  endtask

  task automatic run(input int kc, input bit stall_on, input bit interfere, input string tag);
    int k = 1;
    int nst = 0;
    int expk;
    @(negedge clk);
    kc_i = KW'(kc); start = 1'b1;
    @(posedge clk);
    while (k < 300) begin
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
      if (k == 1 && kc > 0) check({tag, " R3 busy after start"}, 64'(busy), 64'(1));
      if (done) break;
      if (interfere && k == 2) begin // R5 R6: start and accumulator load while busy
        start = 1'b1; kc_i = KW'(1);
        ld_en = 1'b1; ld_sel = 2'd2; ld_row = '0; ld_data = '1;
      end
      stall = stall_on && (k % 3 == 1);
      if (stall) nst++;
      @(posedge clk);
      k++;
    end
    stall = 1'b0;
    expk = ((kc == 0) ? 2 : kc + 5) + nst;
    check({tag, " R3 R4 done latency"}, 64'(k), 64'(expk));
  endtask

  // R7: row r on cycle r after the request, field j = accumulator (r,j)
  task automatic readout(input string tag, input bit try_start);
    @(negedge clk);
    rd_go = 1'b1;
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      rd_go = 1'b0; start = 1'b0;
      if (try_start && r == 0) begin start = 1'b1; kc_i = KW'(3); end
      check({tag, " R7 out_valid"}, 64'(out_valid), 64'(1));
      check({tag, " R7 out_row"}, 64'(out_row), 64'(r));
      for (int j = 0; j < NR; j++)
        check({tag, " R1 R2 R7 element"}, $signed(out_data[j*AW +: AW]), mc[r][j]);
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    check({tag, " R7 valid drops"}, 64'(out_valid), 64'(0));
    if (try_start) check({tag, " R5 start during readout"}, 64'(busy), 64'(0));
  endtask

  task automatic t_reset();
    check("R10 busy", 64'(busy), 64'(0));
    check("R10 done", 64'(done), 64'(0));
    check("R10 out_valid", 64'(out_valid), 64'(0));
  endtask

  task automatic t_rd_ignored();
    @(negedge clk);
    rd_go = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      rd_go = 1'b0;
      check("R8 readout before done", 64'(out_valid), 64'(0));
    end
  endtask

  task automatic t_kc0();
    for (int i = 0; i < NR; i++)
      for (int j = 0; j < NR; j++) mc[i][j] = '0;
    run(0, 1'b0, 1'b0, "kc0");
    readout("R10 reset accumulators", 1'b0);
  endtask

  task automatic t_basic();
    fill_ab(1, 1'b0); load_ab(); load_c(5, 1'b0); model(8);
    run(8, 1'b0, 1'b0, "R2 basic");
    readout("R2 basic", 1'b0);
  endtask

  task automatic t_stall();
    fill_ab(2, 1'b0); load_ab(); load_c(9, 1'b0); model(7);
    run(7, 1'b1, 1'b0, "R4 stall");
    readout("R4 stall", 1'b0);
  endtask

  task automatic t_chain();
    fill_ab(3, 1'b0); load_ab(); model(5);
    run(5, 1'b0, 1'b0, "R9 chain");
    readout("R9 chain", 1'b0);
  endtask

  task automatic t_interfere();
    fill_ab(4, 1'b0); load_ab(); load_c(2, 1'b0); model(6);
    run(6, 1'b0, 1'b1, "R5 R6 interfere");
    readout("R5 R6 interfere", 1'b1);
  endtask

  task automatic t_extreme();
    fill_ab(0, 1'b1); load_ab(); load_c(0, 1'b1); model(16);
    run(16, 1'b0, 1'b0, "R2 extreme");
    readout("R2 extreme", 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rd_ignored();
    t_kc0();
    t_basic();
    t_stall();
    t_chain();
    t_interfere();
    t_extreme();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule